// File: doc/BRIEF.md
# Character Grid Raster Address Generator

This block follows the raster of a video signal and works out, for every dot clock, which cell of a 24-column by 12-row character grid is under the beam and which dot of the 12-wide by 18-tall glyph belongs there. It counts horizontal sync pulses from the last vertical sync pulse to find the first text scan line, and counts dot-clock enables from the last horizontal sync pulse to find the first text dot. From there it steps the dot column, the column, the dot row and the row. Font lookup and video level generation sit downstream and consume these addresses.

Each glyph dot can be stretched over one, two or three dot clocks and over one, two or three scan lines. The first text row has its own pair of stretch codes; every later row shares a second pair. A row-count option shortens the grid to ten rows. Columns that would fall past the next horizontal sync are cut off by that sync; scan lines after the last glyph line of the last row show nothing until the next vertical sync.

Top module: `char_raster_addr`

## Requirements
- R1: While `rst_n` is low, and after it, until the first stimulus, `row`, `col`, `dot_y` and `dot_x` are 0 and `active` is 0.
- R2: After a `vsync` pulse, the Nth following `hsync` pulse starts text (row 0, dot row 0) when N equals 20 + 2·`vpos` with `std625` = 0, or 25 + 2·`vpos` with `std625` = 1; before that `active` stays 0.
- R3: After an `hsync` pulse on a text line, the first text dot (column 0, dot column 0) is reached on the (2·`hpos`)th `dot_en` pulse; with `hpos` = 0 it is reached at the `hsync` itself.
- R4: With stretch 1, each `dot_en` pulse advances `dot_x` through 0..11, then `col` by one; after column 23 dot 11 the next pulse ends the text part of the line (`active` = 0). Cycles without `dot_en` leave `dot_x` and `col` unchanged.
- R5: A 2-bit horizontal stretch code gives the number of `dot_en` pulses per glyph dot: 2'b00 → 1, 2'b01 → 2, 2'b10 → 3, 2'b11 → 1.
- R6: A 2-bit vertical stretch code gives the number of scan lines per glyph dot row, with the same mapping as R5.
- R7: Row 0 uses `hsz_first` and `vsz_first`; every row from 1 upward uses `hsz_rest` and `vsz_rest`.
- R8: With `ten_rows` = 0 the grid has rows 0..11, with `ten_rows` = 1 rows 0..9; after dot row 17 of the last row, `active` stays 0 until the next `vsync`, which restarts the count.
- R9: `active` is 1 only when the beam is inside the grid vertically and horizontally and `disp_en` = 1; `disp_en` = 0 forces `active` to 0 without stopping the address counters.
- R10: `hsync` takes priority over `dot_en` in the same cycle and returns `col` and `dot_x` to 0; `vsync` ends any text area at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dot_en | input | 1 | One-cycle dot-clock enable |
| hsync | input | 1 | One-cycle horizontal sync pulse |
| vsync | input | 1 | One-cycle vertical sync pulse |
| disp_en | input | 1 | Display enable |
| std625 | input | 1 | 1 selects 625-line offset (25), 0 selects 525-line offset (20) |
| ten_rows | input | 1 | 1 limits the grid to 10 rows |
| vpos | input | 6 | Vertical start, weight 2 scan lines |
| hpos | input | 6 | Horizontal start, weight 2 dot clocks |
| vsz_first | input | 2 | Vertical stretch code for row 0 |
| vsz_rest | input | 2 | Vertical stretch code for rows 1 and up |
| hsz_first | input | 2 | Horizontal stretch code for row 0 |
| hsz_rest | input | 2 | Horizontal stretch code for rows 1 and up |
| row | output | 4 | Display memory row |
| col | output | 5 | Display memory column |
| dot_y | output | 5 | Dot row inside the glyph |
| dot_x | output | 4 | Dot column inside the glyph |
| active | output | 1 | Beam inside grid and display enabled |

## Verification
Every address output is a register, so the effect of an `hsync`, `vsync` or `dot_en` pulse seen at one rising edge is visible on the ports one cycle later, and `active` follows `disp_en` in the same cycle. The bench drives each pulse for exactly one clock from the falling edge and samples at the next falling edge, so every check sees the state after a counted number of pulses and the expected values are plain arithmetic on those counts: scan lines since `vsync` against 20 or 25 plus twice `vpos`, and dot pulses since `hsync` against twice `hpos` plus the stretch factor times the dot index.

// File: rtl/char_raster_addr.sv
module char_raster_addr #(
  parameter int COLS     = 24,
  parameter int ROWS     = 12,
  parameter int ROWS_ALT = 10,
  parameter int CELL_W   = 12,
  parameter int CELL_H   = 18,
  parameter int POSW     = 6,
  parameter int LINEW    = 10,
  parameter int OFF_525  = 20,
  parameter int OFF_625  = 25
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      dot_en,
  input  logic                      hsync,
  input  logic                      vsync,
  input  logic                      disp_en,
  input  logic                      std625,
  input  logic                      ten_rows,
  input  logic [POSW-1:0]           vpos,
  input  logic [POSW-1:0]           hpos,
  input  logic [1:0]                vsz_first,
  input  logic [1:0]                vsz_rest,
  input  logic [1:0]                hsz_first,
  input  logic [1:0]                hsz_rest,
  output logic [$clog2(ROWS)-1:0]   row,
  output logic [$clog2(COLS)-1:0]   col,
  output logic [$clog2(CELL_H)-1:0] dot_y,
  output logic [$clog2(CELL_W)-1:0] dot_x,
  output logic                      active
);
  localparam int RW = $clog2(ROWS);
  localparam int CW = $clog2(COLS);
  localparam int YW = $clog2(CELL_H);
  localparam int XW = $clog2(CELL_W);
  localparam int HW = POSW + 1;
  localparam logic [RW-1:0]    ROW_END  = RW'(ROWS - 1);
  localparam logic [RW-1:0]    ROW_END2 = RW'(ROWS_ALT - 1);
  localparam logic [CW-1:0]    COL_END  = CW'(COLS - 1);
  localparam logic [YW-1:0]    DY_END   = YW'(CELL_H - 1);
  localparam logic [XW-1:0]    DX_END   = XW'(CELL_W - 1);
  localparam logic [LINEW-1:0] LOFF_A   = LINEW'(OFF_525);
  localparam logic [LINEW-1:0] LOFF_B   = LINEW'(OFF_625);

  function automatic logic [1:0] rep_last(input logic [1:0] code);
    return (code == 2'b10) ? 2'd2 : (code == 2'b01) ? 2'd1 : 2'd0;
  endfunction

  logic [LINEW-1:0] vline;
  logic             vin, hin;
  logic [1:0]       vrep, hrep;
  logic [HW-1:0]    hcnt;

  wire              first_row = (row == '0);
  wire [1:0]        vlast     = rep_last(first_row ? vsz_first : vsz_rest);
  wire [1:0]        hlast     = rep_last(first_row ? hsz_first : hsz_rest);
  wire [RW-1:0]     row_end   = ten_rows ? ROW_END2 : ROW_END;
  wire [LINEW-1:0]  vstart    = (std625 ? LOFF_B : LOFF_A) + LINEW'({vpos, 1'b0});
  wire [LINEW-1:0]  vline_nx  = vline + 1'b1;
  wire [HW-1:0]     hstart    = {hpos, 1'b0};
  wire [HW-1:0]     hcnt_nx   = hcnt + 1'b1;

  assign active = vin && hin && disp_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vline <= '0; vin <= 1'b0; vrep <= '0; row <= '0; dot_y <= '0;
    end else if (vsync) begin
      vline <= '0; vin <= 1'b0; vrep <= '0; row <= '0; dot_y <= '0;
    end else if (hsync) begin
      if (vline != '1) vline <= vline_nx;
      if (!vin) begin
        if (vline != '1 && vline_nx == vstart) begin
          vin <= 1'b1; vrep <= '0; row <= '0; dot_y <= '0;
        end
      end else if (vrep == vlast) begin
        vrep <= '0;
        if (dot_y == DY_END) begin
          dot_y <= '0;
          if (row == row_end) vin <= 1'b0;
          else row <= row + 1'b1;
        end else begin
          dot_y <= dot_y + 1'b1;
        end
      end else begin
        vrep <= vrep + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0; hin <= 1'b0; hrep <= '0; col <= '0; dot_x <= '0;
    end else if (hsync) begin
      hcnt <= '0; hin <= (hpos == '0); hrep <= '0; col <= '0; dot_x <= '0;
    end else if (dot_en) begin
      if (!hin) begin
        if (hcnt != '1) begin
          hcnt <= hcnt_nx;
          if (hcnt_nx == hstart) hin <= 1'b1;
        end
      end else if (hrep == hlast) begin
        hrep <= '0;
        if (dot_x == DX_END) begin
          dot_x <= '0;
          if (col == COL_END) hin <= 1'b0;
          else col <= col + 1'b1;
        end else begin
          dot_x <= dot_x + 1'b1;
        end
      end else begin
        hrep <= hrep + 1'b1;
      end
    end
  end
endmodule

// File: rtl/char_raster_addr_chk.sv
module char_raster_addr_chk #(
  parameter int COLS = 24, parameter int ROWS = 12, parameter int ROWS_ALT = 10,
  parameter int CELL_W = 12, parameter int CELL_H = 18
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      dot_en,
  input logic                      hsync,
  input logic                      vsync,
  input logic                      disp_en,
  input logic                      ten_rows,
  input logic [$clog2(ROWS)-1:0]   row,
  input logic [$clog2(COLS)-1:0]   col,
  input logic [$clog2(CELL_H)-1:0] dot_y,
  input logic [$clog2(CELL_W)-1:0] dot_x,
  input logic                      active
);
  // R1
  reset_zero_chk: assert property (@(posedge clk) !rst_n |=> (row == '0 && col == '0 && dot_x == '0 && dot_y == '0));
  // R4
  dot_range_chk: assert property (@(posedge clk) disable iff (!rst_n) (int'(dot_x) < CELL_W && int'(col) < COLS && int'(dot_y) < CELL_H));
  // R4
  hold_no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n) (!dot_en && !hsync) |=> ($stable(dot_x) && $stable(col)));
  // R8
  row_limit_chk: assert property (@(posedge clk) disable iff (!rst_n) (active && ten_rows) |-> (int'(row) < ROWS_ALT));
  // R9
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) active |-> disp_en);
  // R10
  hsync_home_chk: assert property (@(posedge clk) disable iff (!rst_n) hsync |=> (dot_x == '0 && col == '0));
  // R10
  vsync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) vsync |=> (!active && row == '0 && dot_y == '0));
endmodule

bind char_raster_addr char_raster_addr_chk #(
  .COLS(COLS), .ROWS(ROWS), .ROWS_ALT(ROWS_ALT), .CELL_W(CELL_W), .CELL_H(CELL_H)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .hsync(hsync), .vsync(vsync),
  .disp_en(disp_en), .ten_rows(ten_rows), .row(row), .col(col),
  .dot_y(dot_y), .dot_x(dot_x), .active(active)
);

// File: tb/char_raster_addr_test.sv
module char_raster_addr_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dot_en = 1'b0, hsync = 1'b0, vsync = 1'b0, disp_en = 1'b1;
  logic std625 = 1'b0, ten_rows = 1'b0;
  logic [5:0] vpos = '0, hpos = '0;
  logic [1:0] vsz_first = '0, vsz_rest = '0, hsz_first = '0, hsz_rest = '0;
  logic [3:0] row;
  logic [4:0] col;
  logic [4:0] dot_y;
  logic [3:0] dot_x;
  logic       active;
  int checks = 0, failures = 0;

  char_raster_addr uut (
    .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .hsync(hsync), .vsync(vsync),
    .disp_en(disp_en), .std625(std625), .ten_rows(ten_rows), .vpos(vpos), .hpos(hpos),
    .vsz_first(vsz_first), .vsz_rest(vsz_rest), .hsz_first(hsz_first), .hsz_rest(hsz_rest),
    .row(row), .col(col), .dot_y(dot_y), .dot_x(dot_x), .active(active)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic hs();
    hsync = 1'b1; @(negedge clk); hsync = 1'b0;
  endtask
  task automatic vs();
    vsync = 1'b1; @(negedge clk); vsync = 1'b0;
  endtask
  task automatic dots(input int n);
    dot_en = 1'b1; repeat (n) @(negedge clk); dot_en = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; repeat (2) @(negedge clk);
    check("R1 row", row, 0); check("R1 col", col, 0);
    check("R1 dot_y", dot_y, 0); check("R1 dot_x", dot_x, 0);
    check("R1 active", active, 0);
    rst_n = 1'b1; @(negedge clk);
    check("R1 active after release", active, 0);
  endtask

  task automatic t_vstart();
    std625 = 1'b0; vpos = 6'd3; hpos = '0;
    vs();
    for (int i = 1; i <= 25; i++) hs();
    check("R2 525 before start", active, 0);
    hs();
    check("R2 525 start active", active, 1);
    check("R2 525 start row", row, 0);
    check("R2 525 start dot_y", dot_y, 0);
    std625 = 1'b1; vpos = 6'd0;
    vs();
    check("R10 vsync clears", active, 0);
    for (int i = 1; i <= 24; i++) hs();
    check("R2 625 before start", active, 0);
    hs();
    check("R2 625 start active", active, 1);
    std625 = 1'b0;
  endtask

  task automatic t_vscale();
    vpos = '0; vsz_first = 2'b10; vsz_rest = 2'b01;
    vs();
    for (int i = 1; i <= 20; i++) hs();
    for (int k = 1; k <= 56; k++) begin
      hs();
      if (k == 2) check("R6 code10 k2", dot_y, 0);
      if (k == 3) check("R6 code10 k3", dot_y, 1);
      if (k == 54) begin check("R7 row1 start", row, 1); check("R7 row1 dot_y", dot_y, 0); end
      if (k == 55) check("R6 code01 k55", dot_y, 0);
      if (k == 56) check("R6 code01 k56", dot_y, 1);
    end
    vsz_first = 2'b11;
    vs();
    for (int i = 1; i <= 21; i++) hs();
    check("R6 code11 one line", dot_y, 1);
    vsz_first = 2'b00; vsz_rest = 2'b00;
  endtask

  task automatic t_rows(input logic ten);
    ten_rows = ten;
    vs();
    for (int i = 1; i <= 20; i++) hs();
    for (int k = 1; k <= 217; k++) begin
      hs();
      if (ten && k == 179) begin
        check("R8 ten last row", row, 9); check("R8 ten last dot", dot_y, 17);
        check("R8 ten last active", active, 1);
      end
      if (ten && k == 180) check("R8 ten end", active, 0);
      if (!ten && k == 180) begin check("R8 twelve row10", row, 10); check("R8 twelve active", active, 1); end
      if (!ten && k == 215) check("R8 twelve last row", row, 11);
      if (!ten && k == 216) check("R8 twelve end", active, 0);
      if (k == 217) check("R8 stays off", active, 0);
    end
    vs();
    for (int i = 1; i <= 20; i++) hs();
    check("R8 restart after vsync", active, 1);
    ten_rows = 1'b0;
  endtask

  task automatic t_horiz();
    vpos = '0; hpos = 6'd5; hsz_first = 2'b00; hsz_rest = 2'b00;
    vs();
    for (int i = 1; i <= 20; i++) hs();
    hs();
    check("R3 after hsync", active, 0);
    dots(9);
    check("R3 before 10th dot", active, 0);
    dots(1);
    check("R3 10th dot active", active, 1);
    check("R3 first col", col, 0); check("R3 first dot", dot_x, 0);
    dots(13);
    check("R4 dot_x j13", dot_x, 1); check("R4 col j13", col, 1);
    dots(274);
    check("R4 last dot_x", dot_x, 11); check("R4 last col", col, 23);
    check("R4 last active", active, 1);
    dots(1);
    check("R4 line end", active, 0);
    dot_en = 1'b1; hsync = 1'b1; @(negedge clk); hsync = 1'b0; dot_en = 1'b0;
    check("R10 hsync beats dot_en col", col, 0);
    check("R10 hsync beats dot_en dot_x", dot_x, 0);
    hpos = '0; hsz_first = 2'b01;
    hs();
    check("R3 hpos0 immediate", active, 1);
    dots(3);
    check("R5 code01 j3", dot_x, 1);
    dots(20);
    check("R5 code01 j23", dot_x, 11);
    dots(1);
    check("R5 code01 j24 col", col, 1);
    hsz_first = 2'b10;
    hs(); dots(5);
    check("R5 code10 j5", dot_x, 1);
    dots(1);
    check("R5 code10 j6", dot_x, 2);
    hsz_first = 2'b11;
    hs(); dots(5);
    check("R5 code11 j5", dot_x, 5);
    repeat (4) @(negedge clk);
    check("R4 hold without dot_en", dot_x, 5);
    for (int i = 1; i <= 13; i++) hs();
    check("R7 at row1", row, 1);
    hsz_first = 2'b10; hsz_rest = 2'b00;
    hs(); dots(5);
    check("R7 row1 uses rest code", dot_x, 5);
    disp_en = 1'b0;
    hs(); dots(3);
    check("R9 disp off active", active, 0);
    check("R9 counters still run", dot_x, 3);
    disp_en = 1'b1; #1;
    check("R9 disp on active", active, 1);
    hsz_first = 2'b00;
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_vstart();
    t_vscale();
    t_rows(1'b1);
    t_rows(1'b0);
    t_horiz();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule